// File: doc/BRIEF.md
# Strip-Mined Vector Element Sequencer

This block walks one vector instruction over an application length `n` that may be larger than the register capacity. It cuts the work into strips. The first strip is the leftover `n mod MVL`, and every strip after it holds exactly MVL elements. A fixed warm-up delay follows each start. After it, the block issues one element index per clock, together with the strip's base offset and its current vector length.

A per-element mask register gates writeback. A compare-not-equal instruction loads one mask bit per issued element from the `cmp_ne` input. A masked instruction then writes back only those elements whose mask bit is set. A plain instruction writes back every element and leaves the mask alone. The arithmetic datapath and the memory are outside this block. The surrounding pipeline supplies the compare outcomes and acts on the index and enable stream.

Top module: `vlm_seq`

## Requirements
- R1: After reset, `elem_valid`, `wb_en`, `mask_wr`, `done` and `busy` are 0, and every mask bit is 1. A masked instruction issued before any compare therefore writes back every element.
- R2: A `start` sampled in IDLE raises `busy` in the next cycle. `elem_valid` then stays low for exactly LAT cycles, and the first element appears in the cycle after those LAT cycles.
- R3: When `n mod MVL` is r > 0, the first strip issues indices 0..r-1, with `vlen` = r and `strip_base` = 0.
- R4: After the first strip, the block issues `n / MVL` further strips. Each has `vlen` = MVL and indices 0..MVL-1. At every strip boundary, `strip_base` grows by the length of the strip just finished.
- R5: When `n mod MVL` is 0, no empty strip is issued, and the first element already belongs to a full strip: `vlen` = MVL, `strip_base` = 0.
- R6: Elements are issued on consecutive cycles with no gap, and exactly `n` cycles have `elem_valid` high.
- R7: `done` is high for exactly one cycle, the cycle after the last element. When `n` = 0, that is the cycle after the warm-up. `busy` falls in the following cycle.
- R8: A `start` pulse while `busy` is high, including the `done` cycle, is ignored. The running stream is unchanged, and no second run follows.
- R9: `op_sel` 2'b01 (compare-set-mask): each issued element raises `mask_wr`, keeps `wb_en` low, and writes mask bit `elem_idx` with the value of `cmp_ne` in that cycle.
- R10: `op_sel` 2'b10 (masked): `wb_en` equals `elem_valid` AND the mask bit selected by `elem_idx`. The mask is not modified.
- R11: `op_sel` 2'b00 and 2'b11 (plain): `wb_en` equals `elem_valid`, `mask_wr` stays 0, and the mask is not modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only in IDLE) |
| n_len | input | N_W | Application vector length |
| op_sel | input | 2 | 00 plain, 01 compare-set-mask, 10 masked, 11 plain |
| cmp_ne | input | 1 | Compare outcome for the element issued this cycle |
| elem_idx | output | $clog2(MVL) | Element index within the current strip |
| strip_base | output | N_W | Offset of the current strip in the application vector |
| vlen | output | $clog2(MVL+1) | Vector-length register of the current strip |
| elem_valid | output | 1 | An element is issued this cycle |
| wb_en | output | 1 | Result of this element is written back |
| mask_wr | output | 1 | Mask bit of this element is written |
| done | output | 1 | One-cycle end-of-instruction pulse |
| busy | output | 1 | An instruction is in progress |

## Verification
The strip walk is tried with several lengths, each aimed at a different defect:
- a length with a short head and two full strips, which tells a wrong base step from a wrong head length;
- an exact multiple of MVL, which exposes an empty head strip;
- a length below MVL, which checks a single partial strip;
- zero, which checks a done pulse with no elements.

The mask is first checked untouched after reset. It is then loaded by compares in a strip and read back through masked writeback in both a full-strip and a split-strip run. A plain run is placed between two masked runs, to show that it leaves the mask alone. Start pulses are injected mid-stream and in the done cycle, to catch a sequencer that restarts.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN  = 2'b00,
    OP_CMPSET = 2'b01,
    OP_GATED  = 2'b10,
    OP_ALT    = 2'b11
  } vlm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WARM,
    ST_RUN,
    ST_FIN
  } vlm_state_e;

  // length of the leading partial strip
  function automatic logic [31:0] head_len(input logic [31:0] total, input logic [31:0] mvl);
    return total % mvl;
  endfunction

  // number of full strips that follow the leading one
  function automatic logic [31:0] body_strips(input logic [31:0] total, input logic [31:0] mvl);
    return total / mvl;
  endfunction

  // writeback decision for one element
  function automatic logic wb_decide(input vlm_op_e op, input logic valid, input logic mbit);
    logic r;
    case (op)
      OP_CMPSET: r = 1'b0;
      OP_GATED:  r = valid & mbit;
      default:   r = valid;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vlm_strip_ctrl.sv
module vlm_strip_ctrl
  import vlm_pkg::*;
#(
  parameter int MVL   = 64,
  parameter int N_W   = 16,
  parameter int LAT   = 3,
  parameter int IDX_W = $clog2(MVL),
  parameter int VL_W  = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [N_W-1:0]   n_i,
  input  vlm_op_e          op_i,
  output logic             run_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_W-1:0]   base_o,
  output logic [VL_W-1:0]  vlen_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             strip_last_o,
  output vlm_op_e          op_o
);

  localparam int LAT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [VL_W-1:0] MVL_VL = VL_W'(MVL);
  localparam logic [LAT_W-1:0] WARM_INIT = LAT_W'(LAT - 1);

  vlm_state_e       state_q;
  logic [LAT_W-1:0] warm_q;
  logic [IDX_W-1:0] idx_q;
  logic [VL_W-1:0]  vlen_q;
  logic [N_W-1:0]   base_q;
  logic [N_W-1:0]   left_q;
  logic [VL_W-1:0]  head_q;
  logic [N_W-1:0]   body_q;
  vlm_op_e          op_q;

  logic [VL_W-1:0]  head_w;
  logic [N_W-1:0]   body_w;
  logic             strip_last;
  logic             accept;

  assign head_w     = VL_W'(head_len(32'(n_i), 32'(MVL)));
  assign body_w     = N_W'(body_strips(32'(n_i), 32'(MVL)));
  assign strip_last = ({1'b0, idx_q} == (vlen_q - VL_W'(1)));
  assign accept     = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      warm_q  <= '0;
      idx_q   <= '0;
      vlen_q  <= '0;
      base_q  <= '0;
      left_q  <= '0;
      head_q  <= '0;
      body_q  <= '0;
      op_q    <= OP_PLAIN;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            head_q  <= head_w;
            body_q  <= body_w;
            op_q    <= op_i;
            warm_q  <= WARM_INIT;
            state_q <= ST_WARM;
          end
        end
        ST_WARM: begin
          if (warm_q == '0) begin
            idx_q  <= '0;
            base_q <= '0;
            if (head_q == '0 && body_q == '0) begin
              state_q <= ST_FIN;
            end else if (head_q != '0) begin
              vlen_q  <= head_q;
              left_q  <= body_q;
              state_q <= ST_RUN;
            end else begin
              vlen_q  <= MVL_VL;
              left_q  <= body_q - N_W'(1);
              state_q <= ST_RUN;
            end
          end else begin
            warm_q <= warm_q - LAT_W'(1);
          end
        end
        ST_RUN: begin
          if (strip_last) begin
            if (left_q == '0) begin
              state_q <= ST_FIN;
            end else begin
              base_q <= base_q + N_W'(vlen_q);
              vlen_q <= MVL_VL;
              left_q <= left_q - N_W'(1);
              idx_q  <= '0;
            end
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o        = (state_q == ST_RUN);
  assign idx_o        = idx_q;
  assign base_o       = base_q;
  assign vlen_o       = vlen_q;
  assign done_o       = (state_q == ST_FIN);
  assign busy_o       = (state_q != ST_IDLE);
  assign strip_last_o = run_o && strip_last;
  assign op_o         = op_q;

endmodule

// File: rtl/vlm_mask_bank.sv
module vlm_mask_bank #(
  parameter int MVL   = 64,
  parameter int IDX_W = $clog2(MVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output logic             bit_o
);

  logic [MVL-1:0] bits_q;

  for (genvar g = 0; g < MVL; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[g] <= 1'b1;
      end else if (wr_i && (idx_i == IDX_W'(g))) begin
        bits_q[g] <= bit_i;
      end
    end
  end

  assign bit_o = bits_q[idx_i];

endmodule

// File: rtl/vlm_issue_gate.sv
module vlm_issue_gate
  import vlm_pkg::*;
(
  input  vlm_op_e op_i,
  input  logic    valid_i,
  input  logic    mask_bit_i,
  output logic    wb_en_o,
  output logic    mask_wr_o
);

  always_comb begin
    wb_en_o   = wb_decide(op_i, valid_i, mask_bit_i);
    mask_wr_o = valid_i && (op_i == OP_CMPSET);
  end

endmodule

// File: rtl/vlm_seq.sv
module vlm_seq
  import vlm_pkg::*;
#(
  parameter int MVL = 64,
  parameter int N_W = 16,
  parameter int LAT = 3,
  localparam int IDX_W = $clog2(MVL),
  localparam int VL_W  = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_W-1:0]   n_len,
  input  logic [1:0]       op_sel,
  input  logic             cmp_ne,
  output logic [IDX_W-1:0] elem_idx,
  output logic [N_W-1:0]   strip_base,
  output logic [VL_W-1:0]  vlen,
  output logic             elem_valid,
  output logic             wb_en,
  output logic             mask_wr,
  output logic             done,
  output logic             busy
);

  vlm_op_e op_run;
  logic    strip_last;
  logic    mask_bit;

  vlm_strip_ctrl #(
    .MVL(MVL), .N_W(N_W), .LAT(LAT), .IDX_W(IDX_W), .VL_W(VL_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .n_i          (n_len),
    .op_i         (vlm_op_e'(op_sel)),
    .run_o        (elem_valid),
    .idx_o        (elem_idx),
    .base_o       (strip_base),
    .vlen_o       (vlen),
    .done_o       (done),
    .busy_o       (busy),
    .strip_last_o (strip_last),
    .op_o         (op_run)
  );

  vlm_mask_bank #(.MVL(MVL), .IDX_W(IDX_W)) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (mask_wr),
    .idx_i (elem_idx),
    .bit_i (cmp_ne),
    .bit_o (mask_bit)
  );

  vlm_issue_gate u_gate (
    .op_i       (op_run),
    .valid_i    (elem_valid),
    .mask_bit_i (mask_bit),
    .wb_en_o    (wb_en),
    .mask_wr_o  (mask_wr)
  );

endmodule

// File: rtl/vlm_seq_chk.sv
module vlm_seq_chk #(
  parameter int MVL   = 64,
  parameter int N_W   = 16,
  parameter int IDX_W = 6,
  parameter int VL_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] elem_idx,
  input logic [N_W-1:0]   strip_base,
  input logic [VL_W-1:0]  vlen,
  input logic             elem_valid,
  input logic             wb_en,
  input logic             mask_wr,
  input logic             done,
  input logic             busy,
  input logic             strip_last
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!elem_valid && !done && !wb_en && !mask_wr));

  p_warm_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !elem_valid);

  p_idx_in_strip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> ({1'b0, elem_idx} < vlen));

  p_base_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && strip_last) |=>
      (!elem_valid || (elem_idx == '0 && vlen == VL_W'(MVL) &&
                       strip_base == $past(strip_base) + N_W'($past(vlen)))));

  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !strip_last) |=>
      (elem_valid && elem_idx == $past(elem_idx) + IDX_W'(1)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_done_no_elem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !elem_valid);

  p_stay_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  p_cmp_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |-> (elem_valid && !wb_en));

  p_wb_needs_elem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> elem_valid);

endmodule

bind vlm_seq vlm_seq_chk #(
  .MVL(MVL), .N_W(N_W), .IDX_W(IDX_W), .VL_W(VL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .elem_idx   (elem_idx),
  .strip_base (strip_base),
  .vlen       (vlen),
  .elem_valid (elem_valid),
  .wb_en      (wb_en),
  .mask_wr    (mask_wr),
  .done       (done),
  .busy       (busy),
  .strip_last (strip_last)
);

// File: tb/vlm_seq_tb.sv
`timescale 1ns/1ps
module vlm_seq_tb_top;

  localparam int TB_MVL = 8;
  localparam int TB_NW  = 12;
  localparam int TB_LAT = 2;
  localparam int TB_IW  = $clog2(TB_MVL);
  localparam int TB_VW  = $clog2(TB_MVL + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [TB_NW-1:0] n_len = '0;
  logic [1:0]       op_sel = 2'b00;
  logic             cmp_ne = 1'b0;
  logic [TB_IW-1:0] elem_idx;
  logic [TB_NW-1:0] strip_base;
  logic [TB_VW-1:0] vlen;
  logic             elem_valid, wb_en, mask_wr, done, busy;

  int checks = 0;
  int fails  = 0;
  bit mdl_mask [TB_MVL];
  bit mask_touched = 1'b0;

  always #2 clk = ~clk;

  vlm_seq #(.MVL(TB_MVL), .N_W(TB_NW), .LAT(TB_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .n_len(n_len), .op_sel(op_sel),
    .cmp_ne(cmp_ne), .elem_idx(elem_idx), .strip_base(strip_base), .vlen(vlen),
    .elem_valid(elem_valid), .wb_en(wb_en), .mask_wr(mask_wr), .done(done), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one instruction; glitch_k>0 pulses start (n=3) in that cycle of the run
  task automatic run_op(input int n, input int op, input logic [31:0] pat, input int glitch_k);
    int r, total;
    r = n % TB_MVL;
    total = TB_LAT + n + 1;
    @(negedge clk);
    start = 1'b1; n_len = TB_NW'(n); op_sel = 2'(op);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= total; k++) begin
      bit ev, ewb, emw;
      int p, e_idx, e_base, e_vl;
      string vtag, wtag;
      p = k - TB_LAT - 1;
      ev = (k > TB_LAT) && (k <= TB_LAT + n);
      e_idx = 0; e_base = 0; e_vl = 0;
      if (ev) begin
        if (p < r) begin
          e_idx = p; e_base = 0; e_vl = r;
        end else begin
          e_idx = (p - r) % TB_MVL;
          e_base = r + ((p - r) / TB_MVL) * TB_MVL;
          e_vl = TB_MVL;
        end
      end
      if (k <= TB_LAT) vtag = "R2";
      else if (r == 0 && p < TB_MVL) vtag = "R5";
      else if (p < r) vtag = "R3";
      else vtag = "R4";
      cmp_ne = ev ? pat[p % 32] : 1'b0;
      if (k == glitch_k) begin start = 1'b1; n_len = TB_NW'(3); end
      else start = 1'b0;
      chk((k <= TB_LAT) ? "R2" : "R6", int'(elem_valid), int'(ev));
      if (ev) begin
        chk(vtag, int'(elem_idx), e_idx);
        chk(vtag, int'(strip_base), e_base);
        chk(vtag, int'(vlen), e_vl);
      end
      chk("R7", int'(done), int'(k == total));
      chk("R8", int'(busy), 1);
      case (op)
        1: begin ewb = 1'b0; wtag = "R9"; end
        2: begin ewb = ev && mdl_mask[e_idx]; wtag = mask_touched ? "R10" : "R1"; end
        default: begin ewb = ev; wtag = "R11"; end
      endcase
      emw = ev && (op == 1);
      chk(wtag, int'(wb_en), int'(ewb));
      chk((op == 1) ? "R9" : "R11", int'(mask_wr), int'(emw));
      if (emw) begin
        mdl_mask[e_idx] = pat[p % 32];
        mask_touched = 1'b1;
      end
      @(negedge clk);
    end
    start = 1'b0;
    cmp_ne = 1'b0;
    for (int j = 0; j < 3; j++) begin
      chk("R8", int'(busy), 0);
      chk("R8", int'(elem_valid), 0);
      chk("R7", int'(done), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1", int'(elem_valid), 0);
    chk("R1", int'(wb_en), 0);
    chk("R1", int'(mask_wr), 0);
    chk("R1", int'(done), 0);
    chk("R1", int'(busy), 0);
  endtask

  task automatic t_fresh_mask;   run_op(10, 2, 32'h0, 0);         endtask // R1 all ones
  task automatic t_split;        run_op(19, 0, 32'h0, 0);         endtask // R3 R4 R6
  task automatic t_exact;        run_op(16, 0, 32'h0, 0);         endtask // R5
  task automatic t_short_alt;    run_op(5, 3, 32'h0, 0);          endtask // R3 R11
  task automatic t_zero;         run_op(0, 0, 32'h0, 0);          endtask // R7
  task automatic t_busy_mid;     run_op(12, 0, 32'h0, 4);         endtask // R8
  task automatic t_busy_fin;     run_op(3, 0, 32'h0, TB_LAT + 4); endtask // R8 done cycle
  task automatic t_cmp_full;     run_op(8, 1, 32'hB2, 0);         endtask // R9
  task automatic t_gated_full;   run_op(8, 2, 32'h0, 0);          endtask // R10
  task automatic t_cmp_split;    run_op(11, 1, 32'h5A3, 0);       endtask // R9 across strips
  task automatic t_gated_split;  run_op(11, 2, 32'h0, 0);         endtask // R10 across strips
  task automatic t_plain_keep;   run_op(6, 0, 32'hFFFF, 0);       endtask // R11 no mask change

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < TB_MVL; i++) mdl_mask[i] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fresh_mask();
    t_split();
    t_exact();
    t_short_alt();
    t_zero();
    t_busy_mid();
    t_busy_fin();
    t_cmp_full();
    t_gated_full();
    t_cmp_split();
    t_gated_split();
    t_plain_keep();
    t_gated_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule